// File: doc/BRIEF.md
# Multichannel Lifting Wavelet Transform Engine

This block runs a streaming, size-efficient discrete wavelet transform over many recording channels at once. On each start strobe one new signed sample per channel is captured from a flat input bus. A sequencer then visits the channels in ascending order and, for each channel, runs through the decomposition levels one after another. Every level sorts its incoming values into even and odd members of a pair. When a pair is complete, two lifting steps produce a detail (high-pass) value, which is emitted. They also produce an approximation (low-pass) value. That value feeds the next level, or it is emitted with an approximation flag when it comes from the deepest level.

One shared multiply-accumulate unit does all of the arithmetic. It has two multipliers and one adder tree, with the result scaled back by an arithmetic right shift. A small register file holds the running state of each channel-level pair: the waiting even value, the previous even value and the previous detail value. A per-channel interval counter decides how deep each channel's walk goes in a given interval. The outputs form one interleaved stream, and every word carries its channel and level.

The control is a five-state machine. ST_IDLE accepts a start strobe and moves to ST_LEVEL. ST_LEVEL stores an even arrival and moves to ST_ADVANCE, or moves to ST_PREDICT on an odd arrival. ST_PREDICT always moves to ST_UPDATE. ST_UPDATE returns to ST_LEVEL for the next level, or moves to ST_ADVANCE after the deepest level. ST_ADVANCE returns to ST_LEVEL for the next channel, or to ST_IDLE after the last channel.

Top module: `lwt_engine`

## Requirements
- R1: After reset, and after any later reset, `busy` and `out_valid` are 0 and all stored pair state and interval counters are zero, so the next results match a freshly started transform.
- R2: At a level, an even arrival produces no output and is held. An odd arrival emits a detail word d = odd + floor((CP0·even + CP1·even_prev) / 2^FRAC), where even_prev is the even value of that level's previous pair (0 after reset).
- R3: The approximation of a completed pair is s = even + floor((CU0·d + CU1·d_prev) / 2^FRAC), where d_prev is that level's previous detail (0 after reset). All results wrap to AW bits, two's complement.
- R4: Level k of a channel receives one value for every 2^k samples of that channel. Below the deepest level, s becomes the next level's input. At the deepest level (NLEV-1), s is emitted with `out_is_approx`=1. Detail words carry `out_is_approx`=0.
- R5: Within one interval, output words appear by ascending channel, then by ascending level. A detail word comes directly before the approximation word of the same channel and level.
- R6: Every output word carries its channel in `out_chan` and its level in `out_level`, with values below NCH and NLEV.
- R7: A start strobe while `busy` is 1 is ignored, and the samples on the bus at that time have no effect.
- R8: Channels keep separate state: the results of one channel depend only on that channel's own sample history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-of-interval strobe |
| samples | input | NCH*DW | One signed sample per channel; channel c in bits [c*DW +: DW] |
| busy | output | 1 | High while an interval is being processed |
| out_valid | output | 1 | Output word valid |
| out_value | output | AW | Signed coefficient value |
| out_chan | output | CHW | Channel index of the word |
| out_level | output | LVW | Level index of the word |
| out_is_approx | output | 1 | 1 for the final approximation, 0 for a detail |

## Verification
The hardest situation to reach from the ports is a pair completing at the deepest level. That happens only in the interval where all of a channel's counter bits are ones, and only with stored even and detail history that has built up through every lower level. The stimulus table runs eight consecutive intervals with different values per channel, including both extreme input codes, and then continues with directed intervals, so the deepest-level path is reached twice with non-zero history. A second start strobe with different samples is sent in the middle of a busy interval, and a reset is applied mid-history, to show that neither leaves a trace in later results.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEVEL,
        ST_PREDICT,
        ST_UPDATE,
        ST_ADVANCE
    } lwt_state_e;

endpackage

// File: rtl/lwt_lift_mac.sv
module lwt_lift_mac #(
    parameter int AW   = 16,
    parameter int CW   = 5,
    parameter int FRAC = 4
) (
    input  logic signed [AW-1:0] base,
    input  logic signed [AW-1:0] op_a,
    input  logic signed [AW-1:0] op_b,
    input  logic signed [CW-1:0] k_a,
    input  logic signed [CW-1:0] k_b,
    output logic signed [AW-1:0] result
);
    localparam int PW = AW + CW + 1;

    logic signed [PW-1:0] prod_a;
    logic signed [PW-1:0] prod_b;
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] scaled;

    always_comb begin
        prod_a = PW'(op_a) * PW'(k_a);
        prod_b = PW'(op_b) * PW'(k_b);
        acc    = prod_a + prod_b;
        // floor division by 2^FRAC
        scaled = acc >>> FRAC;
        result = base + scaled[AW-1:0];
    end

endmodule

// File: rtl/lwt_state_store.sv
module lwt_state_store #(
    parameter int NCH  = 4,
    parameter int NLEV = 3,
    parameter int AW   = 16,
    localparam int DEPTH = NCH * NLEV,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IW-1:0]        idx,
    input  logic                 hold_we,
    input  logic                 ep_we,
    input  logic                 dp_we,
    input  logic signed [AW-1:0] hold_d,
    input  logic signed [AW-1:0] ep_d,
    input  logic signed [AW-1:0] dp_d,
    output logic signed [AW-1:0] hold_q,
    output logic signed [AW-1:0] ep_q,
    output logic signed [AW-1:0] dp_q
);
    logic signed [AW-1:0] hold_m [DEPTH];
    logic signed [AW-1:0] ep_m   [DEPTH];
    logic signed [AW-1:0] dp_m   [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hold_m[i] <= '0;
                ep_m[i]   <= '0;
                dp_m[i]   <= '0;
            end
        end else begin
            if (hold_we) hold_m[idx] <= hold_d;
            if (ep_we)   ep_m[idx]   <= ep_d;
            if (dp_we)   dp_m[idx]   <= dp_d;
        end
    end

    assign hold_q = hold_m[idx];
    assign ep_q   = ep_m[idx];
    assign dp_q   = dp_m[idx];

endmodule

// File: rtl/lwt_engine.sv
module lwt_engine
    import lwt_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NLEV = 3,
    parameter int DW   = 10,
    parameter int AW   = 16,
    parameter int CW   = 5,
    parameter int FRAC = 4,
    parameter logic signed [CW-1:0] CP0 = -5'sd8,
    parameter logic signed [CW-1:0] CP1 = -5'sd8,
    parameter logic signed [CW-1:0] CU0 = 5'sd4,
    parameter logic signed [CW-1:0] CU1 = 5'sd4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LVW = (NLEV > 1) ? $clog2(NLEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NCH*DW-1:0]    samples,
    output logic                 busy,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_value,
    output logic [CHW-1:0]       out_chan,
    output logic [LVW-1:0]       out_level,
    output logic                 out_is_approx
);
    localparam int DEPTH = NCH * NLEV;
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    lwt_state_e state, state_n;

    logic [CHW-1:0]       ch;
    logic [LVW-1:0]       lev;
    logic signed [AW-1:0] x_reg;
    logic signed [AW-1:0] d_reg;
    logic [NCH*DW-1:0]    samp_q;
    logic [NLEV-1:0]      cnt [NCH];

    logic                 last_lev;
    logic                 last_ch;
    logic                 is_even;
    logic [CHW-1:0]       ch_next;
    logic signed [DW-1:0] next_samp;
    logic signed [DW-1:0] first_samp;
    logic [IW-1:0]        idx;

    logic signed [AW-1:0] hold_q, ep_q, dp_q;
    logic                 hold_we, ep_we, dp_we;
    logic signed [AW-1:0] mac_base, mac_a, mac_b, mac_res;
    logic signed [CW-1:0] mac_ka, mac_kb;

    assign last_lev   = (int'(lev) == NLEV - 1);
    assign last_ch    = (int'(ch) == NCH - 1);
    assign is_even    = (cnt[ch][lev] == 1'b0);
    assign ch_next    = last_ch ? '0 : ch + 1'b1;
    assign next_samp  = samp_q[int'(ch_next)*DW +: DW];
    assign first_samp = samples[DW-1:0];
    assign idx        = IW'(int'(ch) * NLEV + int'(lev));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (start) state_n = ST_LEVEL;
            ST_LEVEL:   state_n = is_even ? ST_ADVANCE : ST_PREDICT;
            ST_PREDICT: state_n = ST_UPDATE;
            ST_UPDATE:  state_n = last_lev ? ST_ADVANCE : ST_LEVEL;
            ST_ADVANCE: state_n = last_ch ? ST_IDLE : ST_LEVEL;
            default:    state_n = ST_IDLE;
        endcase
    end

    // shared lifting arithmetic: predict in ST_PREDICT, update in ST_UPDATE
    always_comb begin
        mac_base = x_reg;
        mac_a    = hold_q;
        mac_b    = ep_q;
        mac_ka   = CP0;
        mac_kb   = CP1;
        if (state == ST_UPDATE) begin
            mac_base = hold_q;
            mac_a    = d_reg;
            mac_b    = dp_q;
            mac_ka   = CU0;
            mac_kb   = CU1;
        end
    end

    lwt_lift_mac #(.AW(AW), .CW(CW), .FRAC(FRAC)) u_mac (
        .base   (mac_base),
        .op_a   (mac_a),
        .op_b   (mac_b),
        .k_a    (mac_ka),
        .k_b    (mac_kb),
        .result (mac_res)
    );

    assign hold_we = (state == ST_LEVEL) && is_even;
    assign ep_we   = (state == ST_PREDICT);
    assign dp_we   = (state == ST_UPDATE);

    lwt_state_store #(.NCH(NCH), .NLEV(NLEV), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .hold_we (hold_we),
        .ep_we   (ep_we),
        .dp_we   (dp_we),
        .hold_d  (x_reg),
        .ep_d    (hold_q),
        .dp_d    (d_reg),
        .hold_q  (hold_q),
        .ep_q    (ep_q),
        .dp_q    (dp_q)
    );

    // sequencer datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch     <= '0;
            lev    <= '0;
            x_reg  <= '0;
            d_reg  <= '0;
            samp_q <= '0;
            busy   <= 1'b0;
            for (int c = 0; c < NCH; c++) cnt[c] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        samp_q <= samples;
                        ch     <= '0;
                        lev    <= '0;
                        x_reg  <= AW'(first_samp);
                        busy   <= 1'b1;
                    end
                end
                ST_LEVEL: ;
                ST_PREDICT: d_reg <= mac_res;
                ST_UPDATE: begin
                    if (!last_lev) begin
                        x_reg <= mac_res;
                        lev   <= lev + 1'b1;
                    end
                end
                ST_ADVANCE: begin
                    cnt[ch] <= cnt[ch] + 1'b1;
                    lev     <= '0;
                    if (last_ch) begin
                        busy <= 1'b0;
                    end else begin
                        ch    <= ch_next;
                        x_reg <= AW'(next_samp);
                    end
                end
                default: ;
            endcase
        end
    end

    // output word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_value     <= '0;
            out_chan      <= '0;
            out_level     <= '0;
            out_is_approx <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (state == ST_PREDICT || (state == ST_UPDATE && last_lev)) begin
                out_valid     <= 1'b1;
                out_value     <= mac_res;
                out_chan      <= ch;
                out_level     <= lev;
                out_is_approx <= (state == ST_UPDATE);
            end
        end
    end

    // R5
    pair_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> out_is_approx && !$past(out_is_approx)
            && out_chan == $past(out_chan) && out_level == $past(out_level));

    // R4
    approx_deepest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_approx |-> int'(out_level) == NLEV - 1);

    // R6
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> int'(out_chan) < NCH && int'(out_level) < NLEV);

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(samp_q));

    // R5
    chan_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> int'($past(ch)) == NCH - 1);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) |-> !out_valid);

endmodule

// File: tb/lwt_engine_test.sv
module lwt_engine_test;
    localparam int NCH  = 4;
    localparam int NLEV = 3;
    localparam int DW   = 10;
    localparam int AW   = 16;
    localparam int CW   = 5;
    localparam int FRAC = 4;
    localparam int KP0 = -8;
    localparam int KP1 = -8;
    localparam int KU0 = 4;
    localparam int KU1 = 4;
    localparam int CHW = 2;
    localparam int LVW = 2;
    localparam int NVEC = 8;

    localparam logic [NCH*DW-1:0] VEC [NVEC] = '{
        {10'd40,  10'd30,  10'd20,  10'd10},
        {10'd44,  10'h3F6, 10'd25,  10'd12},
        {10'h200, 10'd31,  10'd19,  10'd200},
        {10'd511, 10'h3E0, 10'd100, 10'd7},
        {10'd3,   10'd0,   10'h3FF, 10'd300},
        {10'h201, 10'd77,  10'd8,   10'h380},
        {10'd15,  10'd511, 10'h250, 10'd1},
        {10'd99,  10'h200, 10'd60,  10'd250}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NCH*DW-1:0] samples = '0;
    logic busy, out_valid, out_is_approx;
    logic signed [AW-1:0] out_value;
    logic [CHW-1:0] out_chan;
    logic [LVW-1:0] out_level;

    int errors = 0;
    int checks = 0;

    int m_hold [NCH][NLEV];
    int m_ep   [NCH][NLEV];
    int m_dp   [NCH][NLEV];
    int m_cnt  [NCH];

    int exp_v [64], exp_c [64], exp_l [64], exp_a [64];
    int exp_n;
    int got_v [64], got_c [64], got_l [64], got_a [64];
    int got_n = 0;

    always #4 clk = ~clk;

    lwt_engine #(.NCH(NCH), .NLEV(NLEV), .DW(DW), .AW(AW), .CW(CW), .FRAC(FRAC),
                 .CP0(KP0), .CP1(KP1), .CU0(KU0), .CU1(KU1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .samples(samples),
        .busy(busy), .out_valid(out_valid), .out_value(out_value),
        .out_chan(out_chan), .out_level(out_level), .out_is_approx(out_is_approx)
    );

    always @(negedge clk) begin
        if (out_valid && got_n < 64) begin
            got_v[got_n] = int'(out_value);
            got_c[got_n] = int'(out_chan);
            got_l[got_n] = int'(out_level);
            got_a[got_n] = int'(out_is_approx);
            got_n++;
        end
    end

    function automatic int wrapw(int v);
        logic signed [AW-1:0] t;
        t = v[AW-1:0];
        return int'(t);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0;
            for (int k = 0; k < NLEV; k++) begin
                m_hold[c][k] = 0; m_ep[c][k] = 0; m_dp[c][k] = 0;
            end
        end
    endtask

    task automatic model_interval(input logic [NCH*DW-1:0] v);
        logic signed [DW-1:0] s10;
        int x, d, s;
        exp_n = 0;
        for (int c = 0; c < NCH; c++) begin
            s10 = v[c*DW +: DW];
            x = int'(s10);
            for (int k = 0; k < NLEV; k++) begin
                if (((m_cnt[c] >> k) & 1) == 0) begin
                    m_hold[c][k] = x;
                    break;
                end
                d = wrapw(x + ((KP0 * m_hold[c][k] + KP1 * m_ep[c][k]) >>> FRAC));
                exp_v[exp_n] = d; exp_c[exp_n] = c; exp_l[exp_n] = k; exp_a[exp_n] = 0;
                exp_n++;
                m_ep[c][k] = m_hold[c][k];
                s = wrapw(m_hold[c][k] + ((KU0 * d + KU1 * m_dp[c][k]) >>> FRAC));
                m_dp[c][k] = d;
                if (k == NLEV - 1) begin
                    exp_v[exp_n] = s; exp_c[exp_n] = c; exp_l[exp_n] = k; exp_a[exp_n] = 1;
                    exp_n++;
                end else begin
                    x = s;
                end
            end
            m_cnt[c] = (m_cnt[c] + 1) % (1 << NLEV);
        end
    endtask

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic compare_interval();
        check(got_n == exp_n, "R5 R4 word count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_v[i] == exp_v[i], "R2 R3 R8 value", got_v[i], exp_v[i]);
            check(got_c[i] == exp_c[i], "R5 R6 channel", got_c[i], exp_c[i]);
            check(got_l[i] == exp_l[i], "R4 R6 level", got_l[i], exp_l[i]);
            check(got_a[i] == exp_a[i], "R4 approx flag", got_a[i], exp_a[i]);
        end
    endtask

    // drive one interval; optionally a second strobe with other data while busy
    task automatic run_interval(input logic [NCH*DW-1:0] v, input bit extra_strobe,
                                input logic [NCH*DW-1:0] junk);
        model_interval(v);
        got_n = 0;
        @(negedge clk);
        samples = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_strobe) begin
            @(negedge clk);
            check(busy == 1'b1, "R7 busy during interval", int'(busy), 1);
            samples = junk; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        compare_interval();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle output", int'(out_valid), 0);

        // table walk: eight intervals reach the deepest level (R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < NVEC; i++) run_interval(VEC[i], 1'b0, '0);

        // R7: strobe with different data while busy is ignored
        run_interval(VEC[3], 1'b1, VEC[6]);
        run_interval(VEC[5], 1'b0, '0);
        // R7: no trace of the ignored strobe in the following intervals
        for (int i = 0; i < 6; i++) run_interval(VEC[(i * 3) % NVEC], 1'b0, '0);

        // R1: reset with non-zero history clears all state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R1 busy after late reset", int'(busy), 0);
        rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < NVEC; i++) run_interval(VEC[NVEC - 1 - i], 1'b0, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule